// File: doc/BRIEF.md
# Cascaded Interrupt Controller With Sub-Sources

This block gathers up to 32 main interrupt lines and a set of sub-source lines and presents them to a processor as two outputs: a fast-interrupt line and a normal-interrupt line. Sub-source requests are latched in their own pending register and filtered by their own mask. Each group of three unmasked sub-source bits then sets one fixed main pending bit. Main requests are latched in a pending register and filtered by a mask. A mode register then sends each active request either to the fast path or to the normal path. The normal path keeps a single latched request, as a one-hot pending word plus the index of that request.

Software reaches the eight 32-bit registers over a simple word-addressed bus. The three pending registers are write-one-to-clear, a read returns data one cycle after the request, and the index register is read-only. Each input runs in either edge mode or level mode, chosen by a static configuration vector. An edge-mode input is synchronised and sets its pending bit once, on a rising edge. A level-mode input keeps setting its pending bit while it stays high. When any input falls, its pending bit is cleared. The arbitration register is stored and read back only and has no effect on arbitration.

Top module: `intc_cascade`

## Requirements
- R1: After reset the registers read as follows: main mask (index 2) 0xFFFFFFFF, arbitration setting (index 3) 0x0000007F, sub mask (index 7) 0x000007FF, all other indices 0. fiq_o and irq_o are low.
- R2: A write of value V clears bits in the registers at indices 0 (main pending), 4 (latched pending) and 6 (sub pending): each bit set in V is cleared and the other bits are kept. A write replaces the registers at indices 1 (mode), 2, 3 and 7. The register at index 5 (latched index) ignores writes.
- R3: A sub pending bit counts as unmasked when its sub mask bit is 0. Any unmasked bit among sub bits 0..2 sets main pending bit 28. Any among 3..5 sets bit 23. Any among 6..8 sets bit 15. Masked sub bits set no main bit.
- R4: A request is active when its main pending bit is 1 and its main mask bit is 0. While any active request has its mode bit set, fiq_o is 1 and the latched pending word is not reloaded. Otherwise fiq_o is 0.
- R5: When no fast request is active, the lowest-numbered active request is the candidate. It is loaded into the latched pending word (one-hot) and its number into the latched index, but only when the latched word is zero or holds a higher-numbered bit.
- R6: irq_o is 1 while the latched pending word is nonzero. It returns to 0 after software clears that word.
- R7: A level-mode input that is held high sets its pending bit again on each cycle, even after software clears the bit. An edge-mode input that is held high leaves its bit cleared once software has cleared it.
- R8: A falling edge on any main or sub input clears that input's pending bit. Bits that fold sets in main pending are not cleared by this.
- R9: If a hardware set and a software clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: bus_rdata_o shows the addressed register one clock after bus_rd_i is sampled high, and holds its value in cycles that follow no read.
- R11: A request whose main mask bit is 1 sets its pending bit, but raises neither fiq_o nor irq_o and changes neither the latched pending word nor the latched index.
- R12: With the default two synchroniser stages, an edge-mode input that rises before clock edge 1 sets its main pending bit at edge 3. If that request is unmasked and in normal mode, and the latched word is empty, irq_o rises at edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_irq_i | input | 32 | Main interrupt request lines |
| main_level_i | input | 32 | Per main line: 1 = level mode, 0 = edge mode |
| sub_irq_i | input | N_SUB | Sub-source request lines |
| sub_level_i | input | N_SUB | Per sub line: 1 = level mode, 0 = edge mode |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word index 0..7 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| fiq_o | output | 1 | Fast interrupt output, registered |
| irq_o | output | 1 | Normal interrupt output, registered |

## Verification
The bench builds the block with its defaults: N_SUB = 11 and SYNC_STAGES = 2. With eleven sub lines, all three fold groups can be exercised, along with masked sub bits outside them. With two stages, the cycle-exact edge-to-pending and pending-to-interrupt latencies of R12 can be checked against fixed counts. Keeping the main width at 32 covers both ends of the lowest-index arbitration and the fixed fold targets 15, 23 and 28.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int REG_W = 32;
  localparam int IDX_W = $clog2(REG_W);
  localparam int FOLD_GROUPS = 3;
  localparam int FOLD_WIDTH  = 3;

  typedef enum logic [2:0] {
    RI_SRC     = 3'd0,
    RI_MODE    = 3'd1,
    RI_MASK    = 3'd2,
    RI_PRIO    = 3'd3,
    RI_PND     = 3'd4,
    RI_OFS     = 3'd5,
    RI_SUBSRC  = 3'd6,
    RI_SUBMASK = 3'd7
  } reg_idx_e;

  // Main pending bit that a sub-source group folds into.
  function automatic int fold_target(input int g);
    case (g)
      0:       return 28;
      1:       return 23;
      default: return 15;
    endcase
  endfunction

  // Main bits set by the unmasked sub-source vector.
  function automatic logic [REG_W-1:0] fold_into_main(input logic [REG_W-1:0] sub_act);
    logic [REG_W-1:0] r;
    r = '0;
    for (int g = 0; g < FOLD_GROUPS; g++) begin
      if (|sub_act[g*FOLD_WIDTH +: FOLD_WIDTH]) r[fold_target(g)] = 1'b1;
    end
    return r;
  endfunction

  // Number of the lowest set bit (0 when empty).
  function automatic logic [IDX_W-1:0] lowest_index(input logic [REG_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // Latched word may be replaced when empty or holding a higher-numbered bit.
  function automatic logic pnd_replace(input logic [REG_W-1:0] cur, input logic [IDX_W-1:0] idx);
    return (cur == '0) || (cur > (REG_W'(1) << idx));
  endfunction

endpackage

// File: rtl/intc_sync_edge.sv
module intc_sync_edge #(
  parameter int W = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] level_mode,
  output logic [W-1:0] set_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] chain [STAGES+1];
  logic [W-1:0] sync_w;
  logic [W-1:0] prev_w;
  logic [W-1:0] rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k <= STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign sync_w = chain[STAGES-1];
  assign prev_w = chain[STAGES];
  assign rise_w = sync_w & ~prev_w;
  assign fall_o = ~sync_w & prev_w;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign set_o[b] = level_mode[b] ? sync_w[b] : rise_w[b];
    end
  endgenerate

  AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_o & ~level_mode) & $past(set_o & ~level_mode)) == '0); // R7

endmodule

// File: rtl/intc_pending.sv
module intc_pending
  import intc_pkg::*;
#(
  parameter int N_SUB = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] main_set,
  input  logic [REG_W-1:0] main_fall,
  input  logic [REG_W-1:0] main_w1c,
  input  logic [N_SUB-1:0] sub_set,
  input  logic [N_SUB-1:0] sub_fall,
  input  logic [N_SUB-1:0] sub_w1c,
  input  logic [N_SUB-1:0] sub_mask,
  output logic [REG_W-1:0] srcpnd,
  output logic [N_SUB-1:0] subpnd,
  output logic [REG_W-1:0] fold_set
);

  logic [N_SUB-1:0] sub_active;
  logic [REG_W-1:0] srcpnd_n;
  logic [N_SUB-1:0] subpnd_n;

  assign sub_active = subpnd & ~sub_mask;
  assign fold_set   = fold_into_main(REG_W'(sub_active));

  // Hardware set is ORed last, so it wins over a same-cycle clear.
  assign srcpnd_n = (srcpnd & ~main_w1c & ~main_fall) | main_set | fold_set;
  assign subpnd_n = (subpnd & ~sub_w1c & ~sub_fall) | sub_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcpnd <= '0;
      subpnd <= '0;
    end else begin
      srcpnd <= srcpnd_n;
      subpnd <= subpnd_n;
    end
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (srcpnd & $past(main_set)) == $past(main_set)); // R9
  AST_FOLD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (srcpnd & $past(fold_set)) == $past(fold_set)); // R3
  AST_SUB_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (subpnd & $past(sub_fall)) == '0); // R8

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] srcpnd,
  input  logic [REG_W-1:0] mask,
  input  logic [REG_W-1:0] mode,
  input  logic [REG_W-1:0] pnd_w1c,
  output logic [REG_W-1:0] intpnd,
  output logic [IDX_W-1:0] offset,
  output logic             fiq_cond,
  output logic             fiq_o,
  output logic             irq_o
);

  logic [REG_W-1:0] active;
  logic [IDX_W-1:0] cand;
  logic [REG_W-1:0] pnd_base;
  logic             load;
  logic [REG_W-1:0] intpnd_n;

  assign active   = srcpnd & ~mask;
  assign fiq_cond = |(active & mode);
  assign cand     = lowest_index(active);
  assign pnd_base = intpnd & ~pnd_w1c;
  assign load     = !fiq_cond && (active != '0) && pnd_replace(pnd_base, cand);
  assign intpnd_n = load ? (REG_W'(1) << cand) : pnd_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intpnd <= '0;
      offset <= '0;
      fiq_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      intpnd <= intpnd_n;
      if (load) offset <= cand;
      fiq_o  <= fiq_cond;
      irq_o  <= (intpnd_n != '0);
    end
  end

  AST_PND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(intpnd)); // R5
  AST_OFS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (intpnd != '0) |-> intpnd[offset]); // R5
  AST_FIQ_FREEZES_PND: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_cond && pnd_w1c == '0) |=> $stable(intpnd)); // R4
  AST_ONLY_LOWER_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
    (intpnd != '0 && pnd_w1c == '0) |=> (intpnd <= $past(intpnd))); // R5

endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
  import intc_pkg::*;
#(
  parameter int N_SUB = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      main_irq_i,
  input  logic [31:0]      main_level_i,
  input  logic [N_SUB-1:0] sub_irq_i,
  input  logic [N_SUB-1:0] sub_level_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             fiq_o,
  output logic             irq_o
);

  localparam logic [REG_W-1:0] MASK_RST    = '1;
  localparam logic [REG_W-1:0] PRIO_RST    = REG_W'(32'h7F);
  localparam logic [N_SUB-1:0] SUBMASK_RST = '1;

  reg_idx_e         widx;
  logic [REG_W-1:0] mode_q, mask_q, prio_q;
  logic [N_SUB-1:0] submask_q;

  logic [REG_W-1:0] main_set, main_fall;
  logic [N_SUB-1:0] sub_set, sub_fall;
  logic [REG_W-1:0] main_w1c, pnd_w1c;
  logic [N_SUB-1:0] sub_w1c;
  logic [REG_W-1:0] srcpnd, intpnd, fold_set;
  logic [N_SUB-1:0] subpnd;
  logic [IDX_W-1:0] offset;
  logic             fiq_cond;
  logic [REG_W-1:0] rd_mux;

  assign widx     = reg_idx_e'(bus_addr_i);
  assign main_w1c = (bus_wr_i && widx == RI_SRC)    ? bus_wdata_i : '0;
  assign pnd_w1c  = (bus_wr_i && widx == RI_PND)    ? bus_wdata_i : '0;
  assign sub_w1c  = (bus_wr_i && widx == RI_SUBSRC) ? bus_wdata_i[N_SUB-1:0] : '0;

  intc_sync_edge #(.W(REG_W), .STAGES(SYNC_STAGES)) u_main_sync (
    .clk(clk), .rst_n(rst_n), .din(main_irq_i), .level_mode(main_level_i),
    .set_o(main_set), .fall_o(main_fall)
  );

  intc_sync_edge #(.W(N_SUB), .STAGES(SYNC_STAGES)) u_sub_sync (
    .clk(clk), .rst_n(rst_n), .din(sub_irq_i), .level_mode(sub_level_i),
    .set_o(sub_set), .fall_o(sub_fall)
  );

  intc_pending #(.N_SUB(N_SUB)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .main_set(main_set), .main_fall(main_fall), .main_w1c(main_w1c),
    .sub_set(sub_set), .sub_fall(sub_fall), .sub_w1c(sub_w1c),
    .sub_mask(submask_q),
    .srcpnd(srcpnd), .subpnd(subpnd), .fold_set(fold_set)
  );

  intc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .srcpnd(srcpnd), .mask(mask_q), .mode(mode_q), .pnd_w1c(pnd_w1c),
    .intpnd(intpnd), .offset(offset), .fiq_cond(fiq_cond),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  // Plain read-write configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      mask_q    <= MASK_RST;
      prio_q    <= PRIO_RST;
      submask_q <= SUBMASK_RST;
    end else if (bus_wr_i) begin
      case (widx)
        RI_MODE:    mode_q    <= bus_wdata_i;
        RI_MASK:    mask_q    <= bus_wdata_i;
        RI_PRIO:    prio_q    <= bus_wdata_i;
        RI_SUBMASK: submask_q <= bus_wdata_i[N_SUB-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (widx)
      RI_SRC:     rd_mux = srcpnd;
      RI_MODE:    rd_mux = mode_q;
      RI_MASK:    rd_mux = mask_q;
      RI_PRIO:    rd_mux = prio_q;
      RI_PND:     rd_mux = intpnd;
      RI_OFS:     rd_mux = REG_W'(offset);
      RI_SUBSRC:  rd_mux = REG_W'(subpnd);
      default:    rd_mux = REG_W'(submask_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd_i) |-> $stable(bus_rdata_o)); // R10
  AST_MASKED_NO_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((srcpnd & ~mask_q) == '0) |=> !fiq_o); // R11
  AST_FIQ_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_cond |=> fiq_o); // R4

endmodule

// File: tb/tb_intc_cascade.sv
module tb_intc_cascade;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 11;

  localparam logic [2:0] A_SRC = 3'd0, A_MODE = 3'd1, A_MASK = 3'd2, A_PRIO = 3'd3,
                         A_PND = 3'd4, A_OFS = 3'd5, A_SUB = 3'd6, A_SUBMASK = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   main_irq = '0, main_level = '0;
  logic [NS-1:0] sub_irq = '0, sub_level = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          fiq, irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_cascade #(.N_SUB(NS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .main_irq_i(main_irq), .main_level_i(main_level),
    .sub_irq_i(sub_irq), .sub_level_i(sub_level),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 fiq_o after reset", 32'(fiq), 32'd0);
    chk("R1 irq_o after reset", 32'(irq), 32'd0);
    chk_reg("R1 main pending", A_SRC, 32'h0);
    chk_reg("R1 mode", A_MODE, 32'h0);
    chk_reg("R1 main mask", A_MASK, 32'hFFFF_FFFF);
    chk_reg("R1 arbitration setting", A_PRIO, 32'h7F);
    chk_reg("R1 latched pending", A_PND, 32'h0);
    chk_reg("R1 latched index", A_OFS, 32'h0);
    chk_reg("R1 sub pending", A_SUB, 32'h0);
    chk_reg("R1 sub mask", A_SUBMASK, 32'h7FF);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr_reg(A_PRIO, 32'h15);
    chk_reg("R2 arbitration setting replaced", A_PRIO, 32'h15);
    wr_reg(A_MODE, 32'h5A00_0000);
    chk_reg("R2 mode replaced", A_MODE, 32'h5A00_0000);
    wr_reg(A_MODE, 32'h0);
    wr_reg(A_SUBMASK, 32'h3A5);
    chk_reg("R2 sub mask replaced", A_SUBMASK, 32'h3A5);
    wr_reg(A_SUBMASK, 32'h7FF);
    wr_reg(A_OFS, 32'h1F);
    chk_reg("R2 latched index ignores writes", A_OFS, 32'h0);
    // R10: data stays put when no read follows
    rd_reg(A_PRIO, v);
    idle(2);
    chk("R10 rdata holds without read", rdata, 32'h15);
  endtask

  task automatic t_edge_irq;
    wr_reg(A_MASK, ~((32'd1 << 5) | (32'd1 << 9)));
    main_irq[9] = 1'b1;
    idle(3);
    chk("R12 irq_o low after edge 3", 32'(irq), 32'd0);
    idle(1);
    chk("R12 irq_o high after edge 4", 32'(irq), 32'd1);
    chk_reg("R5 latched pending bit 9", A_PND, 32'd1 << 9);
    chk_reg("R5 latched index 9", A_OFS, 32'd9);
    main_irq[5] = 1'b1;
    idle(6);
    chk_reg("R5 lower request replaces", A_PND, 32'd1 << 5);
    chk_reg("R5 latched index 5", A_OFS, 32'd5);
    chk_reg("R2 main pending holds both", A_SRC, (32'd1 << 5) | (32'd1 << 9));
    wr_reg(A_SRC, 32'd1 << 5);
    chk_reg("R2 clear-one main pending", A_SRC, 32'd1 << 9);
    wr_reg(A_PND, 32'd1 << 5);
    idle(2);
    chk_reg("R5 reload after clear", A_PND, 32'd1 << 9);
    wr_reg(A_SRC, 32'd1 << 9);
    wr_reg(A_PND, 32'd1 << 9);
    idle(4);
    chk_reg("R7 edge input stays cleared", A_SRC, 32'h0);
    chk("R6 irq_o low after clear", 32'(irq), 32'd0);
    main_irq[5] = 1'b0; main_irq[9] = 1'b0;
    idle(4);
  endtask

  task automatic t_level;
    main_level[7] = 1'b1;
    wr_reg(A_MASK, ~(32'd1 << 7));
    main_irq[7] = 1'b1;
    idle(6);
    chk("R6 irq_o high", 32'(irq), 32'd1);
    wr_reg(A_SRC, 32'd1 << 7);
    chk_reg("R9 R7 level set beats clear", A_SRC, 32'd1 << 7);
    main_irq[7] = 1'b0;
    idle(6);
    chk_reg("R8 fall clears main pending", A_SRC, 32'h0);
    wr_reg(A_PND, 32'd1 << 7);
    idle(2);
    chk("R6 irq_o low after level drop", 32'(irq), 32'd0);
    main_level[7] = 1'b0;
  endtask

  task automatic t_fiq;
    wr_reg(A_MODE, 32'd1 << 20);
    wr_reg(A_MASK, ~((32'd1 << 20) | (32'd1 << 2)));
    main_irq[20] = 1'b1; main_irq[2] = 1'b1;
    idle(6);
    chk("R4 fiq_o high", 32'(fiq), 32'd1);
    chk("R4 irq_o held low", 32'(irq), 32'd0);
    chk_reg("R4 latched pending frozen", A_PND, 32'h0);
    main_irq[20] = 1'b0;
    idle(6);
    chk("R4 fiq_o low", 32'(fiq), 32'd0);
    chk("R4 irq_o after fast cleared", 32'(irq), 32'd1);
    chk_reg("R5 latched bit 2", A_PND, 32'd1 << 2);
    chk_reg("R5 latched index 2", A_OFS, 32'd2);
    main_irq[2] = 1'b0;
    idle(4);
    wr_reg(A_PND, 32'd1 << 2);
    wr_reg(A_MODE, 32'h0);
    idle(2);
    chk("R6 irq_o low", 32'(irq), 32'd0);
  endtask

  task automatic t_masked;
    wr_reg(A_MASK, 32'hFFFF_FFFF);
    main_irq[12] = 1'b1;
    idle(6);
    chk_reg("R11 masked still pending", A_SRC, 32'd1 << 12);
    chk("R11 masked irq_o", 32'(irq), 32'd0);
    chk("R11 masked fiq_o", 32'(fiq), 32'd0);
    chk_reg("R11 latched word untouched", A_PND, 32'h0);
    chk_reg("R11 latched index untouched", A_OFS, 32'd2);
    main_irq[12] = 1'b0;
    idle(6);
    chk_reg("R8 fall clears masked bit", A_SRC, 32'h0);
  endtask

  task automatic t_sub;
    wr_reg(A_MASK, ~((32'd1 << 28) | (32'd1 << 23) | (32'd1 << 15)));
    wr_reg(A_SUBMASK, 32'h7FF & ~(32'd1 << 4));
    sub_irq[1] = 1'b1; sub_irq[4] = 1'b1;
    idle(8);
    chk_reg("R3 sub pending", A_SUB, 32'h12);
    chk_reg("R3 only group 1 folds", A_SRC, 32'd1 << 23);
    chk_reg("R3 latched bit 23", A_PND, 32'd1 << 23);
    wr_reg(A_SUBMASK, 32'h7FF & ~((32'd1 << 4) | (32'd1 << 1) | (32'd1 << 7)));
    idle(4);
    chk_reg("R3 group 0 folds to 28", A_SRC, (32'd1 << 23) | (32'd1 << 28));
    chk_reg("R5 higher bit does not replace", A_PND, 32'd1 << 23);
    sub_irq[7] = 1'b1;
    idle(8);
    chk_reg("R3 group 2 folds to 15", A_SRC, (32'd1 << 23) | (32'd1 << 28) | (32'd1 << 15));
    chk_reg("R5 bit 15 replaces 23", A_PND, 32'd1 << 15);
    sub_irq = '0;
    idle(6);
    chk_reg("R8 sub falls clear sub pending", A_SUB, 32'h0);
    chk_reg("R8 folded bits stay", A_SRC, (32'd1 << 23) | (32'd1 << 28) | (32'd1 << 15));
    wr_reg(A_SRC, 32'hFFFF_FFFF);
    wr_reg(A_PND, 32'hFFFF_FFFF);
    idle(2);
    chk_reg("R2 all main pending cleared", A_SRC, 32'h0);
    chk("R6 irq_o low at end", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog (all): actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_regs;
    t_edge_irq;
    t_level;
    t_fiq;
    t_masked;
    t_sub;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule